// File: doc/BRIEF.md
# Multicore Boot Release Register Block

This block is a small register unit on a 32-bit memory-mapped bus. It decides when each of up to four processor cores begins executing. Software first stores a boot entry address. It then writes any nonzero value to the reset-control register of a chosen core. The block answers with a single-cycle start request for that core. The request carries the stored entry address and a fixed starting privilege level of 3.

The block also holds a general control register and a standby register, both read/write. Several other locations return fixed status constants and ignore writes. A few addresses are recognised but not implemented: they read zero and ignore writes. Any other offset, any access that is not a full aligned word, reads zero, changes nothing and raises an error pulse. Read data and the error flag are registered, so they appear one cycle after the access.

The start request is a push-only pulse with no ready input, so it has no back-pressure. The receiver must take the request in the cycle it is shown. A core that cannot take it loses it, and software has to write the reset-control register again.

Top module: `core_launch_cfg`

## Requirements
- R1: After reset, the general control register reads 0x20, and the standby and entry-address registers read 0. `bus_rdata`, `bus_err` and `launch_valid` are all 0.
- R2: The general control register (0x184), standby register (0x1A0) and entry-address register (0x1A4) store all 32 bits of a word write. Read data appears on `bus_rdata` in the cycle after a read, and `bus_rdata` is 0 in every other cycle.
- R3: Some locations return fixed values and ignore writes:
  - core k reset-control at offset 0x40·(k+1) reads 0x3;
  - core k control at +0x4 reads 0;
  - core k status at +0x8 reads 0x1;
  - the cluster reset locations 0x000 and 0x140 read 0x1;
  - the clock-gating location 0x144 reads 0x10F.
- R4: A nonzero word write to core k's reset-control register drives `launch_valid` to a one-hot value with bit k set, for exactly the one cycle after the write.
- R5: Alongside a start request, `launch_addr` equals the entry-address register value at the time of the reset-control write, and `launch_el` reads 3.
- R6: A write of zero to a reset-control register produces no start request.
- R7: Offsets 0x1E4, 0x280, 0x284 and 0x288 read 0, ignore writes and raise no error.
- R8: Three kinds of access are errors:
  - an offset not listed above;
  - a size other than word (`bus_size` ≠ 2'b10, where 0 is byte, 1 is half and 3 is reserved);
  - an address with nonzero low two bits.
  An error access reads 0, ignores a write and raises `bus_err` for exactly the one cycle after the access.
- R9: Reads and writes to any location other than a reset-control register never produce a start request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset within the 1 KiB window |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read, otherwise 0 |
| bus_err | output | 1 | One-cycle error pulse after an invalid access |
| launch_valid | output | 4 | One-hot start request, one bit per core |
| launch_addr | output | 32 | Entry address sent with the start request |
| launch_el | output | 2 | Starting privilege level, fixed at 3 |

## Verification
The bench sweeps every word offset of the window three times. It reads the whole window after reset, writes a nonzero pattern to the whole window, and then reads it back. Each response is compared with a value computed from the offset arithmetic. A wrong core-group decode, such as an off-by-one in the group index, shows up as a start request on the wrong core, or as an error or constant where a register should be. A constant location that accidentally stores data fails the read-back pass.

Per-core tests check three cases:
- a zero write must not launch, and a top-bit-only write must launch;
- the request must be one cycle long;
- the request must carry the entry value current at the time of the write.

Sub-word and misaligned accesses aimed at a writable register must raise the error and leave the register unchanged.

// File: rtl/core_launch_pkg.sv
package core_launch_pkg;

  typedef enum logic [3:0] {
    SLOT_BAD,
    SLOT_CORE_RST,
    SLOT_CORE_CTL,
    SLOT_CORE_STAT,
    SLOT_CLUSTER,
    SLOT_GATE,
    SLOT_GEN,
    SLOT_STBY,
    SLOT_ENTRY,
    SLOT_UNIMP
  } slot_e;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  // Window offsets whose behaviour is fixed by the address map
  localparam logic [9:0] OFS_CLUSTER_A = 10'h000;
  localparam logic [9:0] OFS_CLUSTER_B = 10'h140;
  localparam logic [9:0] OFS_GATE      = 10'h144;
  localparam logic [9:0] OFS_GEN       = 10'h184;
  localparam logic [9:0] OFS_STBY      = 10'h1A0;
  localparam logic [9:0] OFS_ENTRY     = 10'h1A4;
  localparam logic [9:0] OFS_NOP_DBG   = 10'h1E4;
  localparam logic [9:0] OFS_NOP_CTR0  = 10'h280;
  localparam logic [9:0] OFS_NOP_CTR1  = 10'h284;
  localparam logic [9:0] OFS_NOP_CTR2  = 10'h288;

  // Per-core group layout: group g (1-based) at g*0x40
  localparam logic [5:0] SUB_RST  = 6'h00;
  localparam logic [5:0] SUB_CTL  = 6'h04;
  localparam logic [5:0] SUB_STAT = 6'h08;

  // Read constants
  localparam logic [31:0] RD_CORE_RST  = 32'h0000_0003;
  localparam logic [31:0] RD_CORE_STAT = 32'h0000_0001;
  localparam logic [31:0] RD_CLUSTER   = 32'h0000_0001;
  localparam logic [31:0] RD_GATE      = 32'h0000_010F;

  // Reset values
  localparam logic [31:0] GEN_RST   = 32'h0000_0020;
  localparam logic [31:0] STBY_RST  = 32'h0000_0000;
  localparam logic [31:0] ENTRY_RST = 32'h0000_0000;

endpackage

// File: rtl/core_launch_decode.sv
module core_launch_decode
  import core_launch_pkg::*;
#(
  parameter int AW        = 10,
  parameter int NUM_CORES = 4,
  parameter int CIW       = 2
) (
  input  logic [AW-1:0]  addr,
  input  logic [1:0]     size,
  output slot_e          slot,
  output logic [CIW-1:0] core
);
  localparam int GW = AW - 6;

  logic [GW-1:0] grp;
  logic [5:0]    sub;
  logic          in_core_range;

  assign grp           = addr[AW-1:6];
  assign sub           = addr[5:0];
  // group 1 belongs to core 0, so the core index is group minus one
  assign core          = CIW'(grp - GW'(1));
  assign in_core_range = (int'(grp) >= 1) && (int'(grp) <= NUM_CORES);

  always_comb begin
    slot = SLOT_BAD;
    if (size != SIZE_WORD || addr[1:0] != 2'b00) begin
      slot = SLOT_BAD;
    end else if (in_core_range && sub == SUB_RST) begin
      slot = SLOT_CORE_RST;
    end else if (in_core_range && sub == SUB_CTL) begin
      slot = SLOT_CORE_CTL;
    end else if (in_core_range && sub == SUB_STAT) begin
      slot = SLOT_CORE_STAT;
    end else begin
      case (addr)
        AW'(OFS_CLUSTER_A), AW'(OFS_CLUSTER_B): slot = SLOT_CLUSTER;
        AW'(OFS_GATE):                          slot = SLOT_GATE;
        AW'(OFS_GEN):                           slot = SLOT_GEN;
        AW'(OFS_STBY):                          slot = SLOT_STBY;
        AW'(OFS_ENTRY):                         slot = SLOT_ENTRY;
        AW'(OFS_NOP_DBG), AW'(OFS_NOP_CTR0),
        AW'(OFS_NOP_CTR1), AW'(OFS_NOP_CTR2):   slot = SLOT_UNIMP;
        default:                                slot = SLOT_BAD;
      endcase
    end
  end
endmodule

// File: rtl/core_launch_regs.sv
module core_launch_regs
  import core_launch_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  slot_e         slot,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] gen_q,
  output logic [DW-1:0] stby_q,
  output logic [DW-1:0] entry_q,
  output logic [DW-1:0] rd_val
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q   <= DW'(GEN_RST);
      stby_q  <= DW'(STBY_RST);
      entry_q <= DW'(ENTRY_RST);
    end else if (wr_en) begin
      case (slot)
        SLOT_GEN:   gen_q   <= wdata;
        SLOT_STBY:  stby_q  <= wdata;
        SLOT_ENTRY: entry_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (slot)
      SLOT_CORE_RST:  rd_val = DW'(RD_CORE_RST);
      SLOT_CORE_STAT: rd_val = DW'(RD_CORE_STAT);
      SLOT_CLUSTER:   rd_val = DW'(RD_CLUSTER);
      SLOT_GATE:      rd_val = DW'(RD_GATE);
      SLOT_GEN:       rd_val = gen_q;
      SLOT_STBY:      rd_val = stby_q;
      SLOT_ENTRY:     rd_val = entry_q;
      default:        rd_val = '0;
    endcase
  end
endmodule

// File: rtl/core_launch_req.sv
module core_launch_req #(
  parameter int DW        = 32,
  parameter int NUM_CORES = 4,
  parameter int CIW       = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [CIW-1:0]       core,
  input  logic [DW-1:0]        entry,
  output logic [NUM_CORES-1:0] valid_q,
  output logic [DW-1:0]        addr_q
);
  logic [NUM_CORES-1:0] hit;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_hit
    assign hit[k] = fire && (core == CIW'(k));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      addr_q  <= '0;
    end else begin
      valid_q <= hit;
      if (fire) addr_q <= entry;
    end
  end
endmodule

// File: rtl/core_launch_cfg.sv
module core_launch_cfg
  import core_launch_pkg::*;
#(
  parameter int              AW        = 10,
  parameter int              DW        = 32,
  parameter int              NUM_CORES = 4,
  parameter logic [1:0]      START_EL  = 2'd3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 bus_err,
  output logic [NUM_CORES-1:0] launch_valid,
  output logic [DW-1:0]        launch_addr,
  output logic [1:0]           launch_el
);
  localparam int CIW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  slot_e          slot;
  logic [CIW-1:0] core;
  logic [DW-1:0]  gen_q, stby_q, entry_q, rd_val;
  logic           wr_en, fire;
  logic [DW-1:0]  rdata_q;
  logic           err_q;

  core_launch_decode #(.AW(AW), .NUM_CORES(NUM_CORES), .CIW(CIW)) u_dec (
    .addr (bus_addr),
    .size (bus_size),
    .slot (slot),
    .core (core)
  );

  assign wr_en = bus_req && bus_we;
  assign fire  = wr_en && (slot == SLOT_CORE_RST) && (bus_wdata != '0);

  core_launch_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .slot    (slot),
    .wdata   (bus_wdata),
    .gen_q   (gen_q),
    .stby_q  (stby_q),
    .entry_q (entry_q),
    .rd_val  (rd_val)
  );

  core_launch_req #(.DW(DW), .NUM_CORES(NUM_CORES), .CIW(CIW)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .core    (core),
    .entry   (entry_q),
    .valid_q (launch_valid),
    .addr_q  (launch_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (bus_req && !bus_we) ? rd_val : '0;
      err_q   <= bus_req && (slot == SLOT_BAD);
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign launch_el = START_EL;
endmodule

// File: rtl/core_launch_checker.sv
module core_launch_checker #(
  parameter int DW        = 32,
  parameter int NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [DW-1:0]        bus_wdata,
  input logic [DW-1:0]        bus_rdata,
  input logic                 bus_err,
  input logic [NUM_CORES-1:0] launch_valid,
  input logic [DW-1:0]        launch_addr,
  input logic [DW-1:0]        entry_q,
  input logic [DW-1:0]        gen_q
);
  assert_onehot_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_valid));

  assert_launch_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid != '0) |-> $past(bus_req && bus_we && bus_wdata != '0));

  assert_launch_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid != '0) |-> (launch_addr == $past(entry_q)));

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(bus_req) && bus_rdata == '0));

  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_req && !bus_we) |-> (bus_rdata == '0));

  assert_gen_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_req && bus_we) |-> $stable(gen_q));

  assert_read_no_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_req && !bus_we) |-> (launch_valid == '0));
endmodule

bind core_launch_cfg core_launch_checker #(.DW(DW), .NUM_CORES(NUM_CORES)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .launch_valid (launch_valid),
  .launch_addr  (launch_addr),
  .entry_q      (entry_q),
  .gen_q        (gen_q)
);

// File: tb/test_core_launch_cfg.sv
module test_core_launch_cfg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'b10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  launch_valid;
  logic [31:0] launch_addr;
  logic [1:0]  launch_el;

  int nvec = 0;
  int nerr = 0;
  logic [31:0] m_gen = 32'h20, m_stby = 32'h0, m_entry = 32'h0;
  logic [31:0] s_rdata;
  logic        s_err;
  logic [3:0]  s_lv;
  logic [31:0] s_la;
  logic [1:0]  s_el;

  always #2 clk = ~clk;

  core_launch_cfg i_core_launch_cfg (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .launch_valid(launch_valid),
    .launch_addr(launch_addr), .launch_el(launch_el)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sample();
    s_rdata = bus_rdata; s_err = bus_err; s_lv = launch_valid;
    s_la = launch_addr; s_el = launch_el;
  endtask

  task automatic access(input logic we, input logic [9:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_req = 1'b0; bus_we = 1'b0;
    sample();
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk);
    #1;
    sample();
  endtask

  // core index of a reset-control offset, or -1
  function automatic int core_of(input logic [9:0] a);
    if (a >= 10'h40 && a < 10'h140 && (a & 10'h3F) == 10'h0) return (int'(a) - 'h40) >> 6;
    return -1;
  endfunction

  function automatic logic is_bad(input logic [9:0] a);
    int sub;
    if (a[1:0] != 2'b00) return 1'b1;
    if (a >= 10'h40 && a < 10'h140) begin
      sub = int'(a) & 'h3F;
      return !(sub == 0 || sub == 4 || sub == 8);
    end
    case (a)
      10'h000, 10'h140, 10'h144, 10'h184, 10'h1A0, 10'h1A4,
      10'h1E4, 10'h280, 10'h284, 10'h288: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    int sub;
    if (is_bad(a)) return 32'h0;
    if (a >= 10'h40 && a < 10'h140) begin
      sub = int'(a) & 'h3F;
      if (sub == 0) return 32'h3;
      if (sub == 8) return 32'h1;
      return 32'h0;
    end
    case (a)
      10'h000, 10'h140: return 32'h1;
      10'h144:          return 32'h10F;
      10'h184:          return m_gen;
      10'h1A0:          return m_stby;
      10'h1A4:          return m_entry;
      default:          return 32'h0;
    endcase
  endfunction

  task automatic read_sweep(input string tag);
    for (int i = 0; i < 256; i++) begin
      logic [9:0] a;
      a = 10'(i * 4);
      access(1'b0, a, 2'b10, 32'h0);
      chk({tag, " R3 R7 rdata"}, s_rdata, exp_rd(a));
      chk({tag, " R8 err"}, 32'(s_err), 32'(is_bad(a)));
      chk({tag, " R9 no launch on read"}, 32'(s_lv), 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    sample();
    chk("R1 rdata at reset", s_rdata, 32'h0);
    chk("R1 err at reset", 32'(s_err), 32'h0);
    chk("R1 launch at reset", 32'(s_lv), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk("R5 launch_el", 32'(s_el), 32'h3);

    // R1: every location after reset
    read_sweep("R1 reset");

    // write sweep: nonzero pattern to every word offset
    for (int i = 0; i < 256; i++) begin
      logic [9:0]  a;
      logic [31:0] d;
      int          c;
      a = 10'(i * 4);
      d = 32'hC300_0000 | 32'(i);
      c = core_of(a);
      access(1'b1, a, 2'b10, d);
      chk("R8 write err", 32'(s_err), 32'(is_bad(a)));
      chk("R2 no rdata on write", s_rdata, 32'h0);
      if (c >= 0) begin
        chk("R4 launch onehot", 32'(s_lv), 32'(1) << c);
        chk("R5 launch addr", s_la, m_entry);
      end else begin
        chk("R9 no launch", 32'(s_lv), 32'h0);
      end
      if (a == 10'h184) m_gen = d;
      if (a == 10'h1A0) m_stby = d;
      if (a == 10'h1A4) m_entry = d;
    end

    // R2 R3 R7: read back, constants unchanged, registers hold data
    read_sweep("R2 readback");

    // per-core launch tests
    for (int k = 0; k < 4; k++) begin
      logic [9:0]  ra;
      logic [31:0] ent;
      ra  = 10'(('h40 * (k + 1)));
      ent = 32'h8000_0000 + 32'(k * 'h1000) + 32'h44;
      access(1'b1, 10'h1A4, 2'b10, ent);
      m_entry = ent;
      access(1'b1, ra, 2'b10, 32'h0);
      chk("R6 zero write no launch", 32'(s_lv), 32'h0);
      access(1'b1, ra, 2'b10, 32'h8000_0000);
      chk("R4 launch bit", 32'(s_lv), 32'(1) << k);
      chk("R5 launch addr", s_la, ent);
      chk("R5 launch el", 32'(s_el), 32'h3);
      idle();
      chk("R4 single cycle", 32'(s_lv), 32'h0);
      // entry changes after launch: next launch carries new value
      access(1'b1, 10'h1A4, 2'b10, ~ent);
      m_entry = ~ent;
      access(1'b1, ra, 2'b10, 32'h1);
      chk("R5 new entry", s_la, ~ent);
      chk("R4 launch again", 32'(s_lv), 32'(1) << k);
    end

    // R8: sub-word sizes to writable registers
    for (int sz = 0; sz < 4; sz++) begin
      if (sz != 2) begin
        access(1'b1, 10'h184, 2'(sz), 32'hDEAD_BEEF);
        chk("R8 size err", 32'(s_err), 32'h1);
        access(1'b1, 10'h040, 2'(sz), 32'h1);
        chk("R8 size no launch", 32'(s_lv), 32'h0);
        access(1'b0, 10'h1A0, 2'(sz), 32'h0);
        chk("R8 size read zero", s_rdata, 32'h0);
      end
    end
    // R8: misaligned
    access(1'b1, 10'h186, 2'b10, 32'h1234_5678);
    chk("R8 misaligned err", 32'(s_err), 32'h1);
    idle();
    chk("R8 err one cycle", 32'(s_err), 32'h0);
    access(1'b0, 10'h184, 2'b10, 32'h0);
    chk("R8 gen unchanged", s_rdata, m_gen);
    chk("R8 no err on good read", 32'(s_err), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule